// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K bytes. The RAM has an 8-bit data path that is read or written one whole byte at a time. It has two chip selects of opposite polarity. The host presents one request at a time: a read or write flag, a 17-bit address and write data. It holds the request until the controller answers with a one-cycle ready pulse. For reads, the captured byte and a valid flag arrive together with that pulse. A request is taken only while the controller is idle, so the host never has to withdraw one.

Every memory strobe comes from a register. Each timing window is a whole number of clock cycles. To get it, the controller takes the minimum time of the chosen speed grade and rounds it up by the clock period. The grade parameter picks the 70, 85 or 100 ns tables. The data bus is split into an output value, a drive enable and an input value. After any read, the controller waits long enough for the memory to release the bus before it drives the bus again.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low and after it is released with no request, the memory is deselected (`memCs1N`=1, `memCs2`=0), `memWeN`=1, `memOeN`=1, `memDqDrive`=0, and both `reqReady` and `rdValid` are 0.
- R2: The memory counts as selected only when `memCs1N`=0 and `memCs2`=1. The two selects always hold opposite levels. When deselected, `memWeN` and `memOeN` are 1 and the bus is not driven.
- R3: During a read, selection runs from acceptance until capture. Throughout it, `memOeN`=0, `memWeN`=1 and `memDqDrive`=0.
- R4: A read samples `memDqIn` into `rdData` on the edge that ends a stretch of N cycles with selection and `memOeN`=0. N = max(ceil(tAA/P), ceil(tOE/P)), where P is the clock period and tAA/tOE are 70/25, 85/30 or 100/50 ns for grades 0, 1 and 2. The memory's address has then been stable and output enable low long enough.
- R5: A write holds `memWeN`=0 for exactly W = max(ceil(tWP/P), ceil(tAW/P), ceil(tDW/P)) cycles. In that time `memAddr` and `memDqOut` stay constant. tWP/tAW/tDW are 35/60/35, 70/75/40 or 80/85/40 ns.
- R6: After `memWeN` rises, selection and address are held for max(ceil(5 ns/P), ceil(tRC/P) − W) cycles, where tRC is 70/85/100 ns. The write's ready pulse arrives exactly at the end of that hold.
- R7: `memDqDrive` is 1 only while the memory is selected and `memWeN`=0.
- R8: At least ceil(30 ns/P) cycles with output enable inactive pass before `memDqDrive` rises again.
- R9: `reqReady` is high for one cycle per transaction. `rdValid` is high only with the `reqReady` of a read.
- R10: `memWeN` and `memOeN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present, held until `reqReady` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Captured read byte |
| rdValid | output | 1 | `rdData` valid, with the read's `reqReady` |
| memAddr | output | 17 | Memory address |
| memCs1N | output | 1 | Active-low chip select |
| memCs2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memDqOut | output | 8 | Value to drive on the data bus |
| memDqDrive | output | 1 | 1 = controller drives the data bus |
| memDqIn | input | 8 | Value read from the data bus |

## Verification
A wrong cycle count in the state machine shows up within one transaction. The bench memory model gives inverted data when a read samples early, and it flags a write pulse, setup or recovery that is short as soon as the strobe or address moves. A wrong state after a read shows up as bus drive inside the release window on the very next write. A ready pulse that lasts too long or comes twice is seen one cycle later. A swapped strobe shows up on the same cycle as a select mismatch or as enables low together.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int T_CYCLE      = 0;
  localparam int T_ADDR_ACC   = 1;
  localparam int T_OE_ACC     = 2;
  localparam int T_WE_PULSE   = 3;
  localparam int T_ADDR_TO_END = 4;
  localparam int T_DATA_SETUP = 5;
  localparam int T_WR_RECOV   = 6;
  localparam int T_OUT_OFF    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RECOVER,
    ST_TURN
  } state_t;

  // Control-to-datapath strobes; pin-level fields give the level for the next cycle.
  typedef struct packed {
    logic load;
    logic capture;
    logic done;
    logic selOn;
    logic oeOn;
    logic weOn;
    logic driveOn;
  } strobe_t;

  function automatic int ceilDiv(int t, int p);
    return (t + p - 1) / p;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Minimum times in ns per speed grade (0 fastest .. 2 slowest).
  function automatic int gradeNs(int grade, int item);
    int g;
    g = (grade < 0) ? 0 : (grade > 2) ? 2 : grade;
    case (item)
      T_CYCLE:       return (g == 0) ? 70 : (g == 1) ? 85 : 100;
      T_ADDR_ACC:    return (g == 0) ? 70 : (g == 1) ? 85 : 100;
      T_OE_ACC:      return (g == 0) ? 25 : (g == 1) ? 30 : 50;
      T_WE_PULSE:    return (g == 0) ? 35 : (g == 1) ? 70 : 80;
      T_ADDR_TO_END: return (g == 0) ? 60 : (g == 1) ? 75 : 85;
      T_DATA_SETUP:  return (g == 0) ? 35 : 40;
      T_WR_RECOV:    return 5;
      T_OUT_OFF:     return 30;
      default:       return 0;
    endcase
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int SPEED_GRADE   = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t strobe
);

  localparam int P = CLK_PERIOD_NS;
  localparam int G = SPEED_GRADE;
  localparam int RD_CYC = maxOf(1, maxOf(ceilDiv(gradeNs(G, T_ADDR_ACC), P),
                                         ceilDiv(gradeNs(G, T_OE_ACC), P)));
  localparam int WR_CYC = maxOf(1, maxOf(ceilDiv(gradeNs(G, T_WE_PULSE), P),
                                   maxOf(ceilDiv(gradeNs(G, T_ADDR_TO_END), P),
                                         ceilDiv(gradeNs(G, T_DATA_SETUP), P))));
  localparam int REC_CYC = maxOf(maxOf(1, ceilDiv(gradeNs(G, T_WR_RECOV), P)),
                                 ceilDiv(gradeNs(G, T_CYCLE), P) - WR_CYC);
  localparam int TURN_CYC = maxOf(1, ceilDiv(gradeNs(G, T_OUT_OFF), P));
  localparam int CNT_MAX = maxOf(maxOf(RD_CYC, WR_CYC), maxOf(REC_CYC, TURN_CYC));
  localparam int CNT_W = maxOf(1, $clog2(CNT_MAX));

  state_t            state, nextState;
  logic [CNT_W-1:0]  cnt, nextCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load  = 1'b1;
          strobe.selOn = 1'b1;
          if (reqWrite) begin
            strobe.weOn    = 1'b1;
            strobe.driveOn = 1'b1;
            nextState      = ST_WRITE;
            nextCnt        = CNT_W'(WR_CYC - 1);
          end else begin
            strobe.oeOn = 1'b1;
            nextState   = ST_READ;
            nextCnt     = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          strobe.capture = 1'b1;
          strobe.done    = 1'b1;
          nextState      = ST_TURN;
          nextCnt        = CNT_W'(TURN_CYC - 1);
        end else begin
          strobe.selOn = 1'b1;
          strobe.oeOn  = 1'b1;
          nextCnt      = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        strobe.selOn = 1'b1;
        if (cnt == '0) begin
          nextState = ST_RECOVER;
          nextCnt   = CNT_W'(REC_CYC - 1);
        end else begin
          strobe.weOn    = 1'b1;
          strobe.driveOn = 1'b1;
          nextCnt        = cnt - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt == '0) begin
          strobe.done = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          strobe.selOn = 1'b1;
          nextCnt      = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqDrive,
  input  logic [DATA_W-1:0] memDqIn
);

  // Pin strobes: every memory control output comes from a flop.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCs1N    <= 1'b1;
      memCs2     <= 1'b0;
      memWeN     <= 1'b1;
      memOeN     <= 1'b1;
      memDqDrive <= 1'b0;
      reqReady   <= 1'b0;
      rdValid    <= 1'b0;
    end else begin
      memCs1N    <= ~strobe.selOn;
      memCs2     <= strobe.selOn;
      memWeN     <= ~strobe.weOn;
      memOeN     <= ~strobe.oeOn;
      memDqDrive <= strobe.driveOn;
      reqReady   <= strobe.done;
      rdValid    <= strobe.capture;
    end
  end

  // Address, write data and read capture registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.load) memAddr <= reqAddr;
      if (strobe.load && strobe.weOn) memDqOut <= reqWdata;
      if (strobe.capture) rdData <= memDqIn;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqDrive,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strobe;

  sram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .SPEED_GRADE  (SPEED_GRADE)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqReady  (reqReady),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .memAddr   (memAddr),
    .memCs1N   (memCs1N),
    .memCs2    (memCs2),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memDqOut  (memDqOut),
    .memDqDrive(memDqDrive),
    .memDqIn   (memDqIn)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCs1N,
  input logic              memCs2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqDrive
);

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (memCs1N || !memCs2) |-> (memWeN && memOeN && !memDqDrive)); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memDqDrive)); // R3
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut))); // R5
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memDqDrive |-> (!memWeN && !memCs1N)); // R7
  AST_NO_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!memOeN) |-> !memDqDrive); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R9
  AST_RDV_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> reqReady); // R9
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN)); // R10

endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;

  localparam int PERIOD_NS = 5;
  localparam int GRADE     = 0;
  // Grade-0 minimum times (ns)
  localparam int NS_RC = 70, NS_AA = 70, NS_OE = 25, NS_WP = 35, NS_AW = 60,
                 NS_DW = 35, NS_WR = 5, NS_OFF = 30;

  function automatic int cyc(int ns);
    return (ns + PERIOD_NS - 1) / PERIOD_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_LAT = mx(cyc(NS_AA), cyc(NS_OE));
  localparam int WE_LOW = mx(cyc(NS_WP), mx(cyc(NS_AW), cyc(NS_DW)));
  localparam int WR_LAT = WE_LOW + mx(cyc(NS_WR), cyc(NS_RC) - WE_LOW);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid;
  logic [7:0]  rdData;
  logic [16:0] memAddr;
  logic        memCs1N, memCs2, memWeN, memOeN, memDqDrive;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hEE;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl #(.CLK_PERIOD_NS(PERIOD_NS), .SPEED_GRADE(GRADE)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr),
    .memCs1N(memCs1N), .memCs2(memCs2), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqDrive(memDqDrive), .memDqIn(memDqIn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dflt(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'h1E, a[16]};
  endfunction

  // ---------------- memory model with timing checks ----------------
  logic [7:0] modelMem [logic [16:0]];
  logic [16:0] prevAddr = '0;
  logic [7:0]  prevDout = '0;
  int addrCnt = 1000, oeCnt = 0, weCnt = 0, doutCnt = 1000;
  int offCnt = 1000, sinceWe = 1000;
  bit wroteRecent = 0, prevReady = 0;

  function automatic logic [7:0] stored(logic [16:0] a);
    return modelMem.exists(a) ? modelMem[a] : dflt(a);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit sel = !memCs1N && memCs2;
      automatic int nAddr = (memAddr == prevAddr) ? addrCnt + 1 : 1;
      automatic int nOe   = (sel && !memOeN) ? oeCnt + 1 : 0;
      automatic int nWe   = (sel && !memWeN) ? weCnt + 1 : 0;
      automatic int nDout = (memDqOut == prevDout) ? doutCnt + 1 : 1;
      if (memCs1N != !memCs2) check(0, "R2 select polarity", memCs1N, !memCs2);
      if (!sel && (!memWeN || !memOeN)) check(0, "R2 strobe while deselected", {memWeN, memOeN}, 3);
      if (!memWeN && !memOeN) check(0, "R10 both enables low", 0, 1);
      if (reqReady && prevReady) check(0, "R9 ready longer than one cycle", 1, 0);
      if (rdValid && !reqReady) check(0, "R9 rdValid without ready", 0, 1);
      if (sel && !memOeN && (!memWeN || memDqDrive))
        check(0, "R3 read strobes", {memWeN, memDqDrive}, 2);
      if (memDqDrive) begin
        check(!memWeN && sel, "R7 drive outside write", {sel, memWeN}, 2);
        check(offCnt * PERIOD_NS >= NS_OFF, "R8 turnaround", offCnt, cyc(NS_OFF));
      end
      if (memAddr != prevAddr) begin
        check(addrCnt * PERIOD_NS >= NS_RC, "R6 cycle time", addrCnt, cyc(NS_RC));
        if (wroteRecent) begin
          check(sinceWe * PERIOD_NS >= NS_WR, "R6 write recovery", sinceWe, cyc(NS_WR));
          wroteRecent = 0;
        end
      end
      if (weCnt > 0 && nWe == 0) begin
        check(weCnt == WE_LOW, "R5 write pulse width", weCnt, WE_LOW);
        check(addrCnt * PERIOD_NS >= NS_AW, "R5 address to end of write", addrCnt, cyc(NS_AW));
        check(doutCnt * PERIOD_NS >= NS_DW, "R5 data setup", doutCnt, cyc(NS_DW));
        modelMem[prevAddr] = prevDout;
        sinceWe = 0;
        wroteRecent = 1;
      end
      if (sel && !memOeN && memWeN)
        memDqIn <= (nAddr * PERIOD_NS >= NS_AA && nOe * PERIOD_NS >= NS_OE)
                   ? stored(memAddr) : ~stored(memAddr);
      else
        memDqIn <= 8'hEE;
      addrCnt   = nAddr;
      oeCnt     = nOe;
      weCnt     = nWe;
      doutCnt   = nDout;
      prevAddr  = memAddr;
      prevDout  = memDqOut;
      offCnt    = (sel && !memOeN) ? 0 : offCnt + 1;
      sinceWe   = sinceWe + 1;
      prevReady = reqReady;
    end
  end

  // ---------------- host side ----------------
  logic [7:0] sb [logic [16:0]];

  task automatic doOp(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int selCnt = 0;
    bit got = 0;
    logic [7:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!got) begin
      @(negedge clk);
      if (!memCs1N) selCnt++;
      if (reqReady) got = 1;
    end
    reqValid = 1'b0;
    check(rdValid == !wr, "R9 rdValid matches op", rdValid, !wr);
    if (wr) begin
      check(selCnt == WR_LAT, "R6 write latency", selCnt, WR_LAT);
      sb[a] = d;
    end else begin
      exp = sb.exists(a) ? sb[a] : dflt(a);
      check(selCnt == RD_LAT, "R4 read latency", selCnt, RD_LAT);
      check(rdData == exp, "R4 read data", rdData, exp);
    end
  endtask

  initial begin : watchdog
    #(PERIOD_NS * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [16:0] pool [16];
    void'($urandom(32'h5EED));
    reqValid = 1'b1; reqWrite = 1'b1;  // request held during reset must be ignored
    repeat (4) @(negedge clk);
    check(memCs1N && !memCs2 && memWeN && memOeN && !memDqDrive && !reqReady && !rdValid,
          "R1 idle in reset", {memCs1N, memCs2, memWeN, memOeN, memDqDrive}, 5'b10110);
    reqValid = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(memCs1N && !memCs2 && memWeN && memOeN && !memDqDrive && !reqReady && !rdValid,
          "R1 idle after reset", {memCs1N, memCs2, memWeN, memOeN, memDqDrive}, 5'b10110);

    // directed corners
    doOp(0, 17'h00000, 8'h00);       // unwritten location
    doOp(1, 17'h00000, 8'hFF);
    doOp(0, 17'h00000, 8'h00);
    doOp(1, 17'h1FFFF, 8'h00);
    doOp(0, 17'h1FFFF, 8'h00);       // read then write: turnaround R8
    doOp(1, 17'h1FFFF, 8'hA5);
    doOp(1, 17'h0AAAA, 8'h5A);       // back-to-back writes
    doOp(0, 17'h1FFFF, 8'h00);
    doOp(0, 17'h0AAAA, 8'h00);       // back-to-back reads

    for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
    pool[0] = 17'h00000; pool[15] = 17'h1FFFF;
    for (int i = 0; i < 400; i++) begin
      doOp(1'($urandom), pool[$urandom % 16], 8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(!reqReady && memCs1N && !memDqDrive, "R9 quiet after last op", reqReady, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule